// File: doc/BRIEF.md
# Open-Load and Over-Temperature Fault Reporter

This block gathers the fault indications of a multi-channel constant-current LED sink stage and reports them on one shared active-low error line. Each channel provides two inputs: an enable, which says that its sink is switched on, and a comparator bit, which says that its output node is sitting below the open-detect voltage. A low node is only a real open LED once the channel has been on long enough for the node to settle. For this reason every channel has a qualification counter, and the channel's open flag is armed only after a programmable number of system clocks of continuous on-time. A single over-temperature comparator bit is also combined onto the error line.

The error line is modelled as the enable of an open-drain pull-down. When the enable is high the pad pulls the shared line low. When it is low the pad is released and an external pull-up, shared by several devices, holds the line high. While the outputs are blanked, open-load faults are hidden from the line so that a controller can tell a thermal fault apart from an open LED. The thermal fault is never hidden. Separately, a status snapshot of the per-channel open flags and the thermal flag is taken when the latch strobe falls. The snapshot is held for serial readback until the next falling strobe.

Top module: `led_fault_monitor`

## Requirements
- R1: A channel's open flag becomes true only after its enable and low bit have been sampled on `QUAL_CYCLES` consecutive rising edges. With both held, `err_pull` first goes to 1 after rising edge `QUAL_CYCLES`+1.
- R2: A qualified channel raises its open flag only while its low bit is 1 and its enable is 1. When either input drops and no other fault is present, `err_pull` returns to 0 at the next rising edge.
- R3: While `hot` is 1, `err_pull` is 1 from the next rising edge on, whatever the value of `blank`. With no other fault present, it returns to 0 one edge after `hot` clears.
- R4: While `blank` is 1, qualified open flags do not drive `err_pull`.
- R5: At a rising edge where `latch` was 1 on the previous edge and is 0 now, `cap_open[i]` takes channel i's open flag and `cap_hot` takes `hot`. The value of `blank` does not affect this capture.
- R6: At every other edge, including the edge where `latch` rises and edges where it stays high, `cap_open` and `cap_hot` keep their values.
- R7: Dropping a channel's enable for a single sampled edge restarts its qualification, so `QUAL_CYCLES` new consecutive on-edges are needed again.
- R8: While `rst_n` is 0, `err_pull`, `cap_open`, `cap_hot` and all qualification counters are 0.
- R9: `err_pull` = 1 means the error line is pulled low. `err_pull` = 0 means the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_on | input | NUM_CH | Per-channel sink enable, bit i = channel i |
| ch_low | input | NUM_CH | Per-channel output-below-threshold comparator bit |
| hot | input | 1 | Over-temperature comparator bit |
| blank | input | 1 | Outputs blanked; hides open faults from the error line |
| latch | input | 1 | Status capture strobe, captured on its falling edge |
| err_pull | output | 1 | Open-drain pull-down enable for the shared error line |
| cap_open | output | NUM_CH | Captured open flags, bit i = channel i |
| cap_hot | output | 1 | Captured thermal flag |

## Verification
The bench first checks the qualification window at its edge. The line must stay released after exactly `QUAL_CYCLES` on-edges and be pulled on the next edge. A counter that is off by one would fire a cycle early or late, and a counter that does not restart would fire early after a one-cycle enable glitch. Blanking is tested with and without a thermal fault present. A mask that hid everything would lose the thermal report, and a missing mask would pull the line on an open LED during blanking. The latch strobe is checked at its rise, while held high and at its fall, including a capture made while blanked. A capture on the wrong edge, or one gated by blanking, shows up as a wrong snapshot.

// File: rtl/ledflt_pkg.sv
package ledflt_pkg;
   // counter width able to hold 0..limit
   function automatic int unsigned cnt_bits(input int unsigned limit);
      int unsigned w;
      w = $clog2(limit + 1);
      return (w < 1) ? 1 : w;
   endfunction
endpackage

// File: rtl/open_qualifier.sv
module open_qualifier #(
   parameter int unsigned QUAL_CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on,
   input  logic low,
   output logic flag
);
   localparam int unsigned CW = ledflt_pkg::cnt_bits(QUAL_CYCLES);
   localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (!on)        cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
   end

   assign flag = on & low & (cnt == LIMIT);
endmodule

// File: rtl/fault_combiner.sv
module fault_combiner #(
   parameter int unsigned NUM_CH  = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] open_vec,
   input  logic              hot,
   input  logic              blank,
   output logic              pull
);
   logic fault;
   assign fault = hot | (~blank & (|open_vec));

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) pull <= 1'b0;
         else        pull <= fault;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk;
      assign pull = rst_n & fault;
   end
endmodule

// File: rtl/status_capture.sv
module status_capture #(
   parameter int unsigned NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,
   input  logic [NUM_CH-1:0] open_vec,
   input  logic              hot,
   output logic [NUM_CH-1:0] cap_open,
   output logic              cap_hot,
   output logic              latch_q
);
   logic fall;
   assign fall = latch_q & ~latch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q  <= 1'b0;
         cap_open <= '0;
         cap_hot  <= 1'b0;
      end else begin
         latch_q <= latch;
         if (fall) begin
            cap_open <= open_vec;
            cap_hot  <= hot;
         end
      end
   end
endmodule

// File: rtl/led_fault_monitor.sv
module led_fault_monitor #(
   parameter int unsigned NUM_CH      = 16,
   parameter int unsigned QUAL_CYCLES = 50,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_on,
   input  logic [NUM_CH-1:0] ch_low,
   input  logic              hot,
   input  logic              blank,
   input  logic              latch,
   output logic              err_pull,
   output logic [NUM_CH-1:0] cap_open,
   output logic              cap_hot
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("led_fault_monitor: NUM_CH must be at least 1");
   end
   if (QUAL_CYCLES < 1) begin : g_bad_qual
      $error("led_fault_monitor: QUAL_CYCLES must be at least 1");
   end

   logic [NUM_CH-1:0] open_vec;
   logic              latch_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      open_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_q (
         .clk  (clk),
         .rst_n(rst_n),
         .on   (ch_on[i]),
         .low  (ch_low[i]),
         .flag (open_vec[i])
      );
   end

   fault_combiner #(.NUM_CH(NUM_CH), .OUT_REG(OUT_REG)) u_comb (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_vec(open_vec),
      .hot     (hot),
      .blank   (blank),
      .pull    (err_pull)
   );

   status_capture #(.NUM_CH(NUM_CH)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch   (latch),
      .open_vec(open_vec),
      .hot     (hot),
      .cap_open(cap_open),
      .cap_hot (cap_hot),
      .latch_q (latch_q)
   );
endmodule

// File: rtl/ledflt_checker.sv
module ledflt_checker #(
   parameter int unsigned NUM_CH  = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_on,
   input logic              hot,
   input logic              blank,
   input logic              latch,
   input logic              latch_q,
   input logic [NUM_CH-1:0] open_vec,
   input logic              err_pull,
   input logic [NUM_CH-1:0] cap_open,
   input logic              cap_hot
);
   if (OUT_REG) begin : g_line
      p_hot_pulls_r3: assert property (@(posedge clk) disable iff (!rst_n)
         hot |=> err_pull);
      p_blank_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (blank && !hot) |=> !err_pull);
      p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!hot && !(|open_vec)) |=> !err_pull);
   end else begin : g_noline
      logic unused_sig;
      assign unused_sig = blank ^ err_pull;
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(latch_q && !latch) |=> $stable({cap_open, cap_hot}));
   p_capture_hot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !latch) |=> (cap_hot == $past(hot)));
   p_capture_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !latch) |=> (cap_open == $past(open_vec)));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_q
      p_fresh_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_on[i]) |-> !open_vec[i]);
   end
endmodule

bind led_fault_monitor ledflt_checker #(.NUM_CH(NUM_CH), .OUT_REG(OUT_REG)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ch_on   (ch_on),
   .hot     (hot),
   .blank   (blank),
   .latch   (latch),
   .latch_q (latch_q),
   .open_vec(open_vec),
   .err_pull(err_pull),
   .cap_open(cap_open),
   .cap_hot (cap_hot)
);

// File: tb/sim_led_fault_monitor.sv
module sim_led_fault_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 16;
   localparam int Q   = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic [NCH-1:0] on, low;
   logic hot, blank, latch;
   logic err_pull, cap_hot;
   logic [NCH-1:0] cap_open;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int       m_cnt [NCH];
   logic     m_err, m_hot, m_lat;
   logic [NCH-1:0] m_cap;

   always #(CLK_PERIOD/2) clk = ~clk;

   led_fault_monitor #(.NUM_CH(NCH), .QUAL_CYCLES(Q), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ch_on(on), .ch_low(low), .hot(hot),
      .blank(blank), .latch(latch), .err_pull(err_pull),
      .cap_open(cap_open), .cap_hot(cap_hot)
   );

   function automatic logic [NCH-1:0] open_now();
      logic [NCH-1:0] v;
      for (int i = 0; i < NCH; i++) v[i] = (m_cnt[i] == Q) && on[i] && low[i];
      return v;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      logic [NCH-1:0] ov;
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
         m_err = 0; m_hot = 0; m_cap = '0; m_lat = 0;
      end else begin
         ov = open_now();
         m_err = hot | (~blank & (|ov));
         if (m_lat && !latch) begin
            m_cap = ov;
            m_hot = hot;
         end
         m_lat = latch;
         for (int i = 0; i < NCH; i++)
            m_cnt[i] = on[i] ? ((m_cnt[i] < Q) ? m_cnt[i] + 1 : Q) : 0;
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk({tag, " err_pull"}, 32'(err_pull), 32'(m_err));
      chk({tag, " cap_open"}, 32'(cap_open), 32'(m_cap));
      chk({tag, " cap_hot"},  32'(cap_hot),  32'(m_hot));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; on = '0; low = '0; hot = 0; blank = 0; latch = 0;
      repeat (3) tick("R8 reset");
      chk("R8 reset err_pull", 32'(err_pull), 32'd0);
      chk("R8 reset cap_open", 32'(cap_open), 32'd0);
      rst_n = 1;

      // R1 qualification window
      on[3] = 1; low[3] = 1;
      repeat (Q) tick("R1");
      chk("R1 still released after QUAL_CYCLES", 32'(err_pull), 32'd0);
      tick("R1");
      chk("R1 pulled after QUAL_CYCLES+1", 32'(err_pull), 32'd1);
      chk("R9 pull enable high on fault", 32'(err_pull), 32'd1);

      // R2 needs low and on
      low[3] = 0; tick("R2");
      chk("R2 released when low drops", 32'(err_pull), 32'd0);
      low[3] = 1; tick("R2");
      chk("R2 pulled again", 32'(err_pull), 32'd1);
      on[3] = 0; tick("R2");
      chk("R2 released when channel off", 32'(err_pull), 32'd0);

      // R7 restart after one-edge glitch
      on[3] = 1;
      repeat (Q-1) tick("R7");
      on[3] = 0; tick("R7");
      on[3] = 1;
      repeat (Q) tick("R7");
      chk("R7 restart still released", 32'(err_pull), 32'd0);
      tick("R7");
      chk("R7 pulled after full window", 32'(err_pull), 32'd1);

      // R4 / R3 blanking
      blank = 1; tick("R4");
      chk("R4 blank masks open", 32'(err_pull), 32'd0);
      hot = 1; tick("R3");
      chk("R3 hot reported while blanked", 32'(err_pull), 32'd1);
      hot = 0; tick("R3");
      chk("R3 hot clears", 32'(err_pull), 32'd0);
      blank = 0; tick("R4");
      chk("R4 unblank reports open", 32'(err_pull), 32'd1);

      // R5 / R6 capture
      latch = 1; tick("R6");
      chk("R6 no capture on rise", 32'(cap_open), 32'd0);
      tick("R6");
      chk("R6 no capture while high", 32'(cap_open), 32'd0);
      latch = 0; tick("R5");
      chk("R5 capture on fall", 32'(cap_open), 32'h0008);
      chk("R5 capture hot clear", 32'(cap_hot), 32'd0);
      blank = 1; hot = 1; on[7] = 1; low[7] = 1;
      latch = 1; tick("R5");
      latch = 0; tick("R5");
      chk("R5 capture under blank", 32'(cap_open), 32'h0008);
      chk("R5 capture hot set", 32'(cap_hot), 32'd1);
      hot = 0; blank = 0; on[3] = 0;
      repeat (Q+2) tick("R6");
      chk("R6 held without strobe", 32'(cap_open), 32'h0008);
      chk("R6 hot held", 32'(cap_hot), 32'd1);

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         for (int i = 0; i < NCH; i++) begin
            if (($urandom % 16) == 0) on[i] = ~on[i];
            low[i] = ($urandom % 3) != 0;
         end
         if (($urandom % 12) == 0) hot = ~hot;
         if (($urandom % 10) == 0) blank = ~blank;
         if (($urandom % 4) == 0)  latch = ~latch;
         tick("random R1 R2 R3 R4 R5 R6 R7");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule